// File: doc/BRIEF.md
# Ring-Cascaded FIFO Slice Chain

This block builds a deep first-in/first-out buffer out of several identical FIFO slices placed in a ring. Every slice sees the same write strobe, write data and read strobe. Only one slice at a time responds to writes: the one that holds the write token. Likewise, only one slice responds to reads: the one that holds the read token. A slice writes its own locations in order. When it writes its last physical location, it hands the write token to the next slice. Reading follows the same pattern with the read token.

Each slice has a first-load input. The slice whose first-load input is low holds both tokens when reset ends. The wrapper ties this input low on slice 0 and high on all other slices. The last slice passes its tokens back to slice 0, which closes the ring.

Each slice drives active-low full and empty flags. The wrapper merges them into composite flags, each of which is asserted only when every slice asserts it. Seen from outside, the chain is one FIFO holding SLICES×DEPTH words. Read data is registered and comes with a valid strobe.

Top module: `chain_fifo_x3`

## Requirements
- R1: During reset and right after it, empty_n is 0, full_n is 1 and rd_valid is 0. Both wr_owner and rd_owner equal 1, meaning slice 0 holds both tokens (bit i of each owner vector stands for slice i).
- R2: Words come out in the order they were accepted, across slice boundaries and across wrap-arounds of the ring.
- R3: A write is accepted when wr_en is high and full_n is high at a rising clock edge. The word lands in the next location of the write-token slice. After the accepted write to that slice's last location, wr_owner moves to the next slice at that same edge.
- R4: A read is accepted when rd_en is high and empty_n is high. It takes the oldest word from the read-token slice. After the accepted read of that slice's last location, rd_owner moves to the next slice at that same edge.
- R5: Both tokens pass from the last slice back to slice 0. After every SLICES×DEPTH accepted writes, wr_owner is 1 again. After every SLICES×DEPTH accepted reads, rd_owner is 1 again.
- R6: full_n is 0 exactly when SLICES×DEPTH words are held. A write while full_n is 0 is ignored: no word is stored and wr_owner does not change.
- R7: empty_n is 0 exactly when no words are held. A read while empty_n is 0 is ignored: rd_valid stays 0 in the next cycle and rd_owner does not change.
- R8: A read and a write accepted at the same edge both take effect, and the word count stays the same.
- R9: rd_valid is 1 in the cycle after an accepted read and 0 otherwise. rd_data holds the word that was read while rd_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Shared write strobe |
| wr_data | input | WIDTH | Write word |
| rd_en | input | 1 | Shared read strobe |
| rd_data | output | WIDTH | Registered read word |
| rd_valid | output | 1 | rd_data holds a word read at the last edge |
| full_n | output | 1 | Composite full flag, active low |
| empty_n | output | 1 | Composite empty flag, active low |
| wr_owner | output | SLICES | One-hot: slice holding the write token |
| rd_owner | output | SLICES | One-hot: slice holding the read token |

## Verification
The bench targets each slice's last-location access and the wrap from the last slice back to slice 0.
- A slice that passes a token one cycle late would leave a dead cycle. The write in that cycle would be lost, and the owner vector would briefly show zero owners.
- A slice that fails to block writes while the chain is full would overwrite the oldest word or move a token. Blocking reads while empty is checked the same way.
- Cycles where a read and a write happen together, including the cycle that crosses a token boundary, show whether the count or a token is updated twice or not at all.
- A composite flag built with the wrong combining operator would report full as soon as the first slice fills.

// File: rtl/chain_fifo_pkg.sv
package chain_fifo_pkg;

  // Index of the slice that feeds slice i in a ring of n slices.
  function automatic int ring_prev(input int i, input int n);
    return (i == 0) ? n - 1 : i - 1;
  endfunction

  // Pointer advance with wrap inside one slice of d locations.
  function automatic int ptr_next(input int p, input int d);
    return (p == d - 1) ? 0 : p + 1;
  endfunction

  // Slice that owns a token after 'moves' accepted accesses.
  function automatic int token_slot(input int moves, input int d, input int n);
    return (moves / d) % n;
  endfunction

endpackage

// File: rtl/chain_token.sv
module chain_token (
  input  logic clk,
  input  logic rst_n,
  input  logic first_n,
  input  logic take,
  input  logic give,
  output logic own
);
  // A token received wins over one given away in the same cycle (single-slice ring).
  always_ff @(posedge clk) begin
    if (!rst_n)    own <= ~first_n;
    else if (take) own <= 1'b1;
    else if (give) own <= 1'b0;
  end
endmodule

// File: rtl/chain_store.sv
module chain_store
  import chain_fifo_pkg::*;
#(
  parameter int WIDTH = 9,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_fire,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_fire,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid,
  output logic             full,
  output logic             empty,
  output logic             wr_last,
  output logic             rd_last
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign wr_last = (wp == AW'(DEPTH - 1));
  assign rd_last = (rp == AW'(DEPTH - 1));

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp       <= '0;
      rp       <= '0;
      cnt      <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_fire;
      if (rd_fire) begin
        rd_data <= mem[rp];
        rp      <= AW'(ptr_next(int'(rp), DEPTH));
      end
      if (wr_fire) wp <= AW'(ptr_next(int'(wp), DEPTH));
      if (wr_fire && !rd_fire)      cnt <= cnt + 1'b1;
      else if (rd_fire && !wr_fire) cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/chain_slice.sv
module chain_slice #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             first_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic             wtok_in,
  input  logic             rtok_in,
  output logic             wtok_out,
  output logic             rtok_out,
  output logic             wr_own,
  output logic             rd_own,
  output logic             wr_fire,
  output logic             rd_fire,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid,
  output logic             full_n,
  output logic             empty_n
);
  logic full, empty, wr_last, rd_last;

  assign wr_fire  = wr_en & wr_own & ~full;
  assign rd_fire  = rd_en & rd_own & ~empty;
  assign wtok_out = wr_fire & wr_last;
  assign rtok_out = rd_fire & rd_last;
  assign full_n   = ~full;
  assign empty_n  = ~empty;

  chain_token u_wtok (
    .clk(clk), .rst_n(rst_n), .first_n(first_n),
    .take(wtok_in), .give(wtok_out), .own(wr_own)
  );

  chain_token u_rtok (
    .clk(clk), .rst_n(rst_n), .first_n(first_n),
    .take(rtok_in), .give(rtok_out), .own(rd_own)
  );

  chain_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_fire(wr_fire), .wr_data(wr_data),
    .rd_fire(rd_fire), .rd_data(rd_data), .rd_valid(rd_valid),
    .full(full), .empty(empty), .wr_last(wr_last), .rd_last(rd_last)
  );
endmodule

// File: rtl/chain_fifo_x3.sv
module chain_fifo_x3
  import chain_fifo_pkg::*;
#(
  parameter int WIDTH  = 9,
  parameter int DEPTH  = 8,
  parameter int SLICES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic              rd_en,
  output logic [WIDTH-1:0]  rd_data,
  output logic              rd_valid,
  output logic              full_n,
  output logic              empty_n,
  output logic [SLICES-1:0] wr_owner,
  output logic [SLICES-1:0] rd_owner
);
  logic [SLICES-1:0] wpass, rpass, wfire, rfire, vld, sfull_n, sempty_n;
  logic [WIDTH-1:0]  sdata [SLICES];

  for (genvar i = 0; i < SLICES; i++) begin : g_slice
    localparam int PREV = ring_prev(i, SLICES);
    chain_slice #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_slice (
      .clk(clk), .rst_n(rst_n),
      .first_n((i == 0) ? 1'b0 : 1'b1),
      .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
      .wtok_in(wpass[PREV]), .rtok_in(rpass[PREV]),
      .wtok_out(wpass[i]), .rtok_out(rpass[i]),
      .wr_own(wr_owner[i]), .rd_own(rd_owner[i]),
      .wr_fire(wfire[i]), .rd_fire(rfire[i]),
      .rd_data(sdata[i]), .rd_valid(vld[i]),
      .full_n(sfull_n[i]), .empty_n(sempty_n[i])
    );
  end

  // Active-low flags: composite asserts only when every slice asserts.
  assign full_n   = |sfull_n;
  assign empty_n  = |sempty_n;
  assign rd_valid = |vld;

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < SLICES; i++)
      if (vld[i]) rd_data = rd_data | sdata[i];
  end
endmodule

// File: rtl/chain_fifo_chk.sv
module chain_fifo_chk #(
  parameter int SLICES = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic              full_n,
  input logic              empty_n,
  input logic              rd_valid,
  input logic [SLICES-1:0] wr_owner,
  input logic [SLICES-1:0] rd_owner,
  input logic [SLICES-1:0] wfire,
  input logic [SLICES-1:0] rfire,
  input logic [SLICES-1:0] wpass,
  input logic [SLICES-1:0] rpass
);
  // R3
  one_wr_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wr_owner) == 1);
  // R4
  one_rd_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rd_owner) == 1);
  // R3
  single_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wfire) && ((wfire & ~wr_owner) == '0));
  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |-> (wfire == '0));
  // R6
  full_holds_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !full_n) |=> $stable(wr_owner));
  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !empty_n) |=> !rd_valid);
  // R9
  valid_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rfire) |=> rd_valid);
  // R5
  wr_token_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|wpass) |=> (wr_owner != $past(wr_owner)));
  // R5
  rd_token_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rpass) |=> (rd_owner != $past(rd_owner)));
  // R6
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_n || empty_n);
endmodule

bind chain_fifo_x3 chain_fifo_chk #(.SLICES(SLICES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
  .full_n(full_n), .empty_n(empty_n), .rd_valid(rd_valid),
  .wr_owner(wr_owner), .rd_owner(rd_owner),
  .wfire(wfire), .rfire(rfire), .wpass(wpass), .rpass(rpass)
);

// File: tb/chain_fifo_x3_bench.sv
module chain_fifo_x3_bench;
  localparam int WIDTH  = 9;
  localparam int DEPTH  = 8;
  localparam int SLICES = 3;
  localparam int CAP    = DEPTH * SLICES;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [WIDTH-1:0] wr_data = '0;
  logic [WIDTH-1:0] rd_data;
  logic rd_valid, full_n, empty_n;
  logic [SLICES-1:0] wr_owner, rd_owner;

  int checks = 0, bad = 0;
  logic [WIDTH-1:0] q [CAP];
  int cnt = 0, wpos = 0, rpos = 0, wtot = 0, rtot = 0;
  int unsigned seed = 32'd1234;

  always #5 clk = ~clk;

  chain_fifo_x3 #(.WIDTH(WIDTH), .DEPTH(DEPTH), .SLICES(SLICES)) u_chain_fifo_x3 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .rd_valid(rd_valid), .full_n(full_n), .empty_n(empty_n),
    .wr_owner(wr_owner), .rd_owner(rd_owner)
  );

  function automatic logic [SLICES-1:0] owner_of(input int moves);
    return SLICES'(1) << ((moves / DEPTH) % SLICES);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Called at a negedge: drive, let one edge pass, check at the next negedge.
  task automatic step(input logic we, input logic [WIDTH-1:0] wd, input logic re);
    logic wacc, racc, was_full, was_empty;
    logic [WIDTH-1:0] exp_d;
    wacc = we && (cnt < CAP);
    racc = re && (cnt > 0);
    was_full = (cnt == CAP);
    was_empty = (cnt == 0);
    exp_d = '0;
    wr_en = we; wr_data = wd; rd_en = re;
    if (racc) begin exp_d = q[rpos]; rpos = (rpos + 1) % CAP; rtot++; end
    if (wacc) begin q[wpos] = wd; wpos = (wpos + 1) % CAP; wtot++; end
    cnt = cnt + int'(wacc) - int'(racc);
    @(posedge clk);
    @(negedge clk);
    check("R9 rd_valid", int'(rd_valid), int'(racc));
    if (racc) check((wacc ? "R8 rd_data" : "R2 rd_data"), int'(rd_data), int'(exp_d));
    check((we && was_full) ? "R6 full_n" : "R6 flag", int'(full_n), int'(cnt != CAP));
    check((re && was_empty) ? "R7 empty_n" : "R7 flag", int'(empty_n), int'(cnt != 0));
    check((wtot > 0 && wtot % CAP == 0) ? "R5 wr_owner" : "R3 wr_owner",
          int'(wr_owner), int'(owner_of(wtot)));
    check((rtot > 0 && rtot % CAP == 0) ? "R5 rd_owner" : "R4 rd_owner",
          int'(rd_owner), int'(owner_of(rtot)));
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 empty_n", int'(empty_n), 0);
    check("R1 full_n", int'(full_n), 1);
    check("R1 rd_valid", int'(rd_valid), 0);
    check("R1 wr_owner", int'(wr_owner), 1);
    check("R1 rd_owner", int'(rd_owner), 1);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 read while empty
    step(1'b0, '0, 1'b1);
    // R3 fill to full, R6 write while full
    for (int i = 0; i < CAP; i++) step(1'b1, WIDTH'(i + 7), 1'b0);
    step(1'b1, 9'h1ff, 1'b0);
    step(1'b1, 9'h155, 1'b0);
    // R8 read and write together while full: only read accepted
    step(1'b1, 9'h0aa, 1'b1);
    // R4/R2 drain to empty, then read while empty
    for (int i = 0; i < CAP; i++) step(1'b0, '0, 1'b1);
    step(1'b0, '0, 1'b1);
    // R8 streaming with both strobes, crossing every slice boundary
    step(1'b1, 9'h011, 1'b0);
    for (int i = 0; i < 3 * CAP; i++) step(1'b1, WIDTH'(i * 5 + 3), 1'b1);
    // Random phases: fill-biased, drain-biased, balanced
    for (int ph = 0; ph < 12; ph++) begin
      for (int i = 0; i < 400; i++) begin
        int pw, pr;
        pw = (ph % 3 == 0) ? 80 : (ph % 3 == 1) ? 25 : 55;
        pr = (ph % 3 == 0) ? 25 : (ph % 3 == 1) ? 80 : 55;
        step(($urandom(seed) % 100) < pw, WIDTH'($urandom(seed)), ($urandom(seed) % 100) < pr);
        seed = seed + 32'd17;
      end
    end
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule